// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register File

This block is the byte-wide, memory-mapped front end of a real-time clock. It occupies the top eight byte addresses of an 11-bit space and decodes everything below them onto a pass-through port for an external RAM. The live calendar counter is a separate block. It presents its current time on a snapshot port and pulses an update strobe each time it advances. It accepts a one-cycle load request carrying new time values.

The host never sees the live counters directly. It reads a visible copy that is refreshed from the snapshot on every counter update. Two control bits suspend that refresh. A read hold freezes a coherent snapshot while the counters keep running. A write hold lets the host stage a new time. When the write hold is cleared, the staged values are pushed to the counter in a single load pulse. The block also holds an oscillator stop bit and a frequency-test bit. The frequency-test bit replaces the seconds LSB with a 512 Hz square wave derived from a 32.768 kHz tick enable. A power-fail flag blocks every bus access.

Top module: `rtc_regfile_top`

## Requirements
- R1: Byte addresses 0x7F8 to 0x7FF select, in order, control, seconds, minutes, hours, day, date, month and year; the time bytes on `cal_now`/`cal_load_val` are packed seconds in bits 7:0 up to year in bits 55:48.
- R2: Control bit 7 is the write hold and bit 6 is the read hold; both read back at those positions.
- R3: While the read hold is 1, the visible time registers ignore counter updates and keep the values captured before it was set.
- R4: After the read hold returns to 0, the visible registers stay unchanged until the next `cal_upd` pulse, which refreshes all seven together.
- R5: While the write hold is 1, host writes to the seven time registers are stored. A control write that clears the hold raises `cal_load` for exactly one cycle, with the staged values on `cal_load_val`.
- R6: While the write hold is 0, host writes to time registers leave the time fields unchanged. Only seconds bit 7 and day bit 6 are taken.
- R7: Seconds bit 7 is the oscillator stop. When it is 1, `osc_run` is 0 and the 512 Hz prescaler does not advance.
- R8: Day bit 6 is the frequency test. When it is 1 and the oscillator runs, seconds bit 0 reads as prescaler bit 5, which toggles every 32 ticks of `tick_32k` counted from reset.
- R9: While `pwr_fail` is 1, every access is ignored. Writes change nothing, the read data of the following cycle is 0x00, and `ram_ce` stays 0.
- R10: Unused bits are dropped on write and read back as 0. The kept widths are seconds 7, minutes 7, hours 6, day 3, date 6, month 5, year 8 and control 2.
- R11: An access below 0x7F8 drives `ram_ce`, and `ram_we` on writes, in the same cycle. Read data is `ram_rdata` one cycle later.
- R12: After reset, both holds, the oscillator stop and the frequency test are 0, the visible time is 0, `cal_load` is 0, and read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 11 | Byte address |
| bus_ce | input | 1 | Access enable, active high |
| bus_we | input | 1 | Write when high, read when low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the access |
| pwr_fail | input | 1 | Supply out of tolerance; blocks accesses |
| ram_ce | output | 1 | External RAM selected this cycle |
| ram_we | output | 1 | External RAM write this cycle |
| ram_rdata | input | 8 | External RAM read data, one cycle after select |
| tick_32k | input | 1 | 32.768 kHz tick enable |
| osc_run | output | 1 | Oscillator running (counter may advance) |
| cal_now | input | 56 | Live time snapshot from the calendar counter |
| cal_upd | input | 1 | Pulse: calendar counter advanced |
| cal_load | output | 1 | Pulse: load `cal_load_val` into the counter |
| cal_load_val | output | 56 | Staged time values |

## Verification
The main function is tried with four hold patterns, each paired with counter update pulses that carry distinct times. With no hold, the visible copy must follow each update. With the read hold set, it must stay on the earlier time. After the read hold is cleared, it must stay put until the next pulse. With the write hold set, host values must survive updates and come out intact on the load pulse. The vectors use a different value per register and out-of-range bits. This separates an address-order mistake from a masking mistake, and the frequency-test and oscillator patterns are timed by counted ticks so that a running prescaler can be told from a stopped one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NTIME = 7;
    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_SEC  = 3'd1;
    localparam logic [2:0] IDX_DAY  = 3'd4;

    typedef struct packed {
        logic       hit_clk;
        logic       hit_ram;
        logic       wr;
        logic [2:0] idx;
    } acc_t;

    // Kept bits of each time register, index 1 = seconds .. 7 = year
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'h3F;
            4:       return 8'h07;
            5:       return 8'h3F;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce,
    input  logic              we,
    input  logic              pwr_fail,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] CLK_BASE = ADDR_W'((1 << ADDR_W) - 8);

    logic live;

    always_comb begin
        live        = ce && !pwr_fail;
        acc.hit_clk = live && (addr >= CLK_BASE);
        acc.hit_ram = live && (addr < CLK_BASE);
        acc.wr      = we;
        acc.idx     = addr[2:0];
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic wave
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run && tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wave = cnt_q[PRESC_W-1];

    assert_presc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
    assert_presc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  acc_t                 acc,
    input  logic [7:0]           wdata,
    input  logic [NTIME*8-1:0]   cal_now,
    input  logic                 cal_upd,
    input  logic                 ft_wave,
    output logic [7:0]           rdata,
    output logic [NTIME*8-1:0]   vis_flat,
    output logic                 load,
    output logic                 osc_stop
);
    typedef struct packed {
        logic                  w;
        logic                  r;
        logic                  osc;
        logic                  ft;
        logic                  load;
        logic [NTIME-1:0][7:0] vis;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        if (!s_q.w && !s_q.r && cal_upd) begin
            for (int k = 0; k < NTIME; k++)
                s_d.vis[k] = cal_now[k*8 +: 8] & field_mask(k + 1);
        end
        if (acc.hit_clk && acc.wr) begin
            if (acc.idx == IDX_CTRL) begin
                s_d.w    = wdata[7];
                s_d.r    = wdata[6];
                s_d.load = s_q.w && !wdata[7];
            end else begin
                if (acc.idx == IDX_SEC) s_d.osc = wdata[7];
                if (acc.idx == IDX_DAY) s_d.ft  = wdata[6];
                if (s_q.w) begin
                    for (int k = 0; k < NTIME; k++)
                        if (acc.idx == 3'(k + 1))
                            s_d.vis[k] = wdata & field_mask(k + 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = 8'h00;
        if (acc.idx == IDX_CTRL) begin
            rdata = {s_q.w, s_q.r, 6'b0};
        end else begin
            for (int k = 0; k < NTIME; k++)
                if (acc.idx == 3'(k + 1)) rdata = s_q.vis[k];
            if (acc.idx == IDX_SEC) begin
                rdata[7] = s_q.osc;
                if (s_q.ft && !s_q.osc) rdata[0] = ft_wave;
            end
            if (acc.idx == IDX_DAY) rdata[6] = s_q.ft;
        end
    end

    assign vis_flat = s_q.vis;
    assign load     = s_q.load;
    assign osc_stop = s_q.osc;

    assert_read_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.r && $past(s_q.r) && !$past(s_q.w)) |-> $stable(s_q.vis));
    assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load |-> (!s_q.w && $past(s_q.w)));
    assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load |=> !s_q.load);
endmodule

// File: rtl/rtc_regfile_top.sv
module rtc_regfile_top
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PRESC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ce,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pwr_fail,
    output logic              ram_ce,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata,
    input  logic              tick_32k,
    output logic              osc_run,
    input  logic [55:0]       cal_now,
    input  logic              cal_upd,
    output logic              cal_load,
    output logic [55:0]       cal_load_val
);
    typedef struct packed {
        logic [7:0] rd;
        logic       sel_clk;
        logic       sel_ram;
        logic       sel_ctrl;
    } rdpath_t;

    acc_t       acc;
    logic [7:0] clk_rdata;
    logic       ft_wave;
    logic       osc_stop;
    rdpath_t    p_d, p_q;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .ce       (bus_ce),
        .we       (bus_we),
        .pwr_fail (pwr_fail),
        .acc      (acc)
    );

    rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .run   (!osc_stop),
        .wave  (ft_wave)
    );

    rtc_shadow_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (bus_wdata),
        .cal_now  (cal_now),
        .cal_upd  (cal_upd),
        .ft_wave  (ft_wave),
        .rdata    (clk_rdata),
        .vis_flat (cal_load_val),
        .load     (cal_load),
        .osc_stop (osc_stop)
    );

    always_comb begin
        p_d          = '0;
        p_d.sel_clk  = acc.hit_clk && !acc.wr;
        p_d.sel_ram  = acc.hit_ram && !acc.wr;
        p_d.sel_ctrl = p_d.sel_clk && (acc.idx == IDX_CTRL);
        if (p_d.sel_clk) p_d.rd = clk_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_rdata = p_q.sel_clk ? p_q.rd : (p_q.sel_ram ? ram_rdata : 8'h00);
    assign ram_ce    = acc.hit_ram;
    assign ram_we    = acc.hit_ram && acc.wr;
    assign osc_run   = !osc_stop;

    assert_pf_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (bus_rdata == 8'h00));
    assert_ctrl_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.sel_ctrl |-> (bus_rdata[5:0] == 6'b0));
endmodule

// File: tb/rtc_regfile_top_tb.sv
module rtc_regfile_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_ce = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pwr_fail = 1'b0;
    logic        ram_ce, ram_we;
    logic [7:0]  ram_rdata = 8'h3C;
    logic        tick_32k = 1'b0;
    logic        osc_run;
    logic [55:0] cal_now = '0;
    logic        cal_upd = 1'b0;
    logic        cal_load;
    logic [55:0] cal_load_val;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    rtc_regfile_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ce(bus_ce),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_fail(pwr_fail), .ram_ce(ram_ce), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .tick_32k(tick_32k), .osc_run(osc_run),
        .cal_now(cal_now), .cal_upd(cal_upd), .cal_load(cal_load),
        .cal_load_val(cal_load_val)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 11'h7F8, 8'h80, 8'h00},  // R2 set write hold
        {1'b0, 11'h7F8, 8'h00, 8'h80},  // R2
        {1'b1, 11'h7F9, 8'h45, 8'h00},  // R5
        {1'b1, 11'h7FA, 8'h30, 8'h00},
        {1'b1, 11'h7FB, 8'hE3, 8'h00},  // R10 top bits dropped
        {1'b1, 11'h7FC, 8'hB5, 8'h00},
        {1'b1, 11'h7FD, 8'hFF, 8'h00},
        {1'b1, 11'h7FE, 8'h12, 8'h00},
        {1'b1, 11'h7FF, 8'h99, 8'h00},
        {1'b0, 11'h7F9, 8'h00, 8'h45},  // R1
        {1'b0, 11'h7FA, 8'h00, 8'h30},
        {1'b0, 11'h7FB, 8'h00, 8'h23},
        {1'b0, 11'h7FC, 8'h00, 8'h05},
        {1'b0, 11'h7FD, 8'h00, 8'h3F},
        {1'b0, 11'h7FE, 8'h00, 8'h12},
        {1'b0, 11'h7FF, 8'h00, 8'h99},
        {1'b0, 11'h7F8, 8'h00, 8'h80}
    };

    function automatic string vec_tag(input int i);
        if (i < 2 || i == 16) return "R2";
        if (i == 4 || i == 11 || i == 12 || i == 13) return "R10";
        if (i >= 9) return "R1";
        return "R5";
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_ce = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_ce = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_ce = 1'b1; bus_we = 1'b0;
        @(negedge clk);
        bus_ce = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_upd();
        @(negedge clk); cal_upd = 1'b1;
        @(negedge clk); cal_upd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_32k = 1'b1;
        repeat (n) @(negedge clk);
        tick_32k = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rdata", bus_rdata, 8'h00);
        check("R12 osc_run", osc_run, 1'b1);
        check("R12 cal_load", cal_load, 1'b0);
        check("R12 load_val", cal_load_val, 56'h0);
        bus_rd(11'h7F8, rv); check("R12 ctrl", rv, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) bus_wr(VEC[i][26:16], VEC[i][15:8]);
            else begin
                bus_rd(VEC[i][26:16], rv);
                check(vec_tag(i), rv, VEC[i][7:0]);
            end
        end

        // R5 staged values survive an update, then load
        cal_now = 56'h11_01_01_01_01_01_01;
        pulse_upd();
        check("R5 staged", cal_load_val, 56'h99_12_3F_05_23_30_45);
        bus_wr(11'h7F8, 8'h00);
        check("R5 load high", cal_load, 1'b1);
        check("R5 load value", cal_load_val, 56'h99_12_3F_05_23_30_45);
        @(negedge clk);
        check("R5 load single", cal_load, 1'b0);

        // R6 writes ignored without write hold
        bus_wr(11'h7F9, 8'h12);
        bus_rd(11'h7F9, rv); check("R6 sec", rv, 8'h45);
        bus_wr(11'h7FA, 8'h55);
        bus_rd(11'h7FA, rv); check("R6 min", rv, 8'h30);

        // Normal refresh
        cal_now = 56'h24_02_29_04_13_07_58;
        pulse_upd();
        bus_rd(11'h7F9, rv); check("R4 refresh sec", rv, 8'h58);
        bus_rd(11'h7FF, rv); check("R4 refresh year", rv, 8'h24);

        // R3 read hold
        bus_wr(11'h7F8, 8'h40);
        cal_now = 56'h24_02_29_04_13_08_59;
        pulse_upd();
        bus_rd(11'h7F9, rv); check("R3 frozen sec", rv, 8'h58);
        bus_rd(11'h7FA, rv); check("R3 frozen min", rv, 8'h07);
        bus_rd(11'h7F8, rv); check("R2 read hold bit", rv, 8'h40);

        // R4 release waits for next update
        bus_wr(11'h7F8, 8'h00);
        bus_rd(11'h7F9, rv); check("R4 still old", rv, 8'h58);
        pulse_upd();
        bus_rd(11'h7F9, rv); check("R4 new sec", rv, 8'h59);
        bus_rd(11'h7FA, rv); check("R4 new min", rv, 8'h08);

        // R7 oscillator stop
        bus_wr(11'h7F9, 8'h80);
        check("R7 osc_run", osc_run, 1'b0);
        bus_rd(11'h7F9, rv); check("R7 sec read", rv, 8'hD9);
        bus_wr(11'h7F9, 8'h00);
        check("R7 osc restart", osc_run, 1'b1);

        // R8 frequency test
        bus_wr(11'h7FC, 8'h40);
        bus_rd(11'h7FC, rv); check("R8 day ft", rv, 8'h44);
        bus_rd(11'h7F9, rv); check("R8 wave 0 ticks", rv, 8'h58);
        ticks(32);
        bus_rd(11'h7F9, rv); check("R8 wave 32 ticks", rv, 8'h59);
        ticks(32);
        bus_rd(11'h7F9, rv); check("R8 wave 64 ticks", rv, 8'h58);
        bus_wr(11'h7F9, 8'h80);
        ticks(32);
        bus_rd(11'h7F9, rv); check("R8 ft off when stopped", rv, 8'hD9);
        bus_wr(11'h7F9, 8'h00);
        bus_rd(11'h7F9, rv); check("R7 prescaler held", rv, 8'h58);

        // R9 power fail
        pwr_fail = 1'b1;
        @(negedge clk);
        bus_addr = 11'h123; bus_ce = 1'b1; bus_we = 1'b0;
        #1 check("R9 ram_ce blocked", ram_ce, 1'b0);
        @(negedge clk); bus_ce = 1'b0;
        bus_wr(11'h7F8, 8'h80);
        bus_rd(11'h7F8, rv); check("R9 read blocked", rv, 8'h00);
        pwr_fail = 1'b0;
        bus_rd(11'h7F8, rv); check("R9 write blocked", rv, 8'h00);

        // R11 RAM pass-through
        @(negedge clk);
        bus_addr = 11'h123; bus_ce = 1'b1; bus_we = 1'b0;
        #1 check("R11 ram_ce", {ram_ce, ram_we}, 2'b10);
        @(negedge clk); bus_ce = 1'b0;
        check("R11 ram data", bus_rdata, 8'h3C);
        bus_addr = 11'h7F7; bus_ce = 1'b1; bus_we = 1'b1;
        #1 check("R11 ram write", {ram_ce, ram_we}, 2'b11);
        @(negedge clk); bus_ce = 1'b0; bus_we = 1'b0;
        bus_rd(11'h7F8, rv); check("R11 top of ram not clock", rv, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule